// File: doc/BRIEF.md
# Interrupt Status Collector with Clear-on-Read

This block gathers the event signals of a two-wire serial bus controller into one raw status word, filters it through a software-writable enable mask, and drives a single interrupt line. Ten of the twelve sources are sticky: a one-cycle pulse on the event input sets the bit, and it stays set until software clears it. The other two sources are live levels that compare the receive and transmit FIFO fill levels against programmable thresholds.

Software clears a sticky source by reading the clear address that belongs to that source. Because each source has its own clear address, software reads the status, then clears exactly the bits it saw, and an event that arrives between those two reads survives. A combined clear address exists for teardown. A separate abort-cause word collects the reasons for a transmit abort and keeps them until the transmit-abort source is cleared.

Top module: `isr_ctrl`

## Requirements
- R1: Bit positions of the raw status word, also used for the mask and the masked status: 0 rx underflow, 1 rx overflow, 2 rx full, 3 tx overflow, 4 tx empty, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop detected, 10 start detected, 11 general call. A pulse on `evt_i[k]` for a sticky source k sets raw bit k at the next clock edge and it stays set without further pulses; the raw word is read at byte address 0x34.
- R2: The mask is read and written at 0x30 and resets to 0x254 (bits 2, 4, 6, 9); the masked status at 0x2c equals raw AND mask.
- R3: The sticky sources, in ascending bit order (0, 1, 3, 5, 6, 7, 8, 9, 10, 11), have clear addresses 0x44, 0x48, ... 0x68 in steps of four. A read of one of them clears only its own bit, and returns zero.
- R4: A read of 0x40 clears every sticky source and the abort-cause word at once.
- R5: A sticky source whose event pulse arrives in the same cycle as the read of its own clear address, or of 0x40, is set after that edge.
- R6: Raw bit 2 is 1 exactly while `rx_level_i` is greater than the rx threshold (0x38); raw bit 4 is 1 exactly while `tx_level_i` is less than or equal to the tx threshold (0x3c). Both thresholds reset to 0. Clear reads do not change these bits, and event pulses on `evt_i[2]` and `evt_i[4]` have no effect.
- R7: The abort-cause word at 0x80 ORs in every `abrt_cause_i` pulse, keeps its value across other reads, and becomes zero after a read of the tx-abort clear address 0x54 (or 0x40).
- R8: `irq_o` equals the OR of the masked status bits one clock edge earlier.
- R9: After reset, the sticky bits, the abort word, the thresholds and `irq_o` are zero and the mask is 0x254; reads of unmapped addresses return zero and writes to read-only addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; clear addresses act on it |
| reg_addr_i | input | 8 | Byte address |
| reg_wdata_i | input | 12 | Write data |
| reg_rdata_o | output | 13 | Read data for the current address, valid in the strobe cycle |
| evt_i | input | 12 | One-cycle event pulses, one per status bit |
| rx_level_i | input | 5 | Receive FIFO fill level |
| tx_level_i | input | 5 | Transmit FIFO fill level |
| abrt_cause_i | input | 13 | Abort-cause pulses ORed into the abort word |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench walks the per-source clear addresses one by one and reads the raw word after each, so a decode that skipped the two level bits in the wrong place would clear a neighbour or nothing. It hits a clear read together with a fresh event on the same source, where a design that gave the clear priority would drop the event. It moves the FIFO levels across each threshold by one and issues clear reads while the level bits are high, catching an off-by-one compare or a level bit that was made sticky. It also checks that the abort word survives unrelated clears and that `irq_o` lags a mask change by exactly one edge.

// File: rtl/isr_pkg.sv
package isr_pkg;
  // Status bit positions (shared by raw, mask and masked words)
  localparam int unsigned SRC_RX_UNDER = 0;
  localparam int unsigned SRC_RX_FULL  = 2;
  localparam int unsigned SRC_TX_EMPTY = 4;
  localparam int unsigned SRC_TX_ABORT = 6;
  localparam int unsigned SRC_STOP     = 9;

  // Register byte offsets
  localparam int unsigned OFS_MASKED   = 'h2c;
  localparam int unsigned OFS_MASK     = 'h30;
  localparam int unsigned OFS_RAW      = 'h34;
  localparam int unsigned OFS_RX_THR   = 'h38;
  localparam int unsigned OFS_TX_THR   = 'h3c;
  localparam int unsigned OFS_CLR_ALL  = 'h40;
  localparam int unsigned OFS_CLR_BASE = 'h44;
  localparam int unsigned OFS_ABORT    = 'h80;

  localparam logic [11:0] LEVEL_SRC_MAP = 12'h014;
  localparam logic [11:0] MASK_RESET    = 12'h254;
endpackage

// File: rtl/isr_level_cmp.sv
module isr_level_cmp #(
  parameter int unsigned LVL_W = 5
) (
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_thr_i,
  input  logic [LVL_W-1:0] tx_thr_i,
  output logic             rx_full_o,
  output logic             tx_empty_o
);
  always_comb begin
    rx_full_o  = (rx_level_i >  rx_thr_i);
    tx_empty_o = (tx_level_i <= tx_thr_i);
  end
endmodule

// File: rtl/isr_latch_bank.sv
module isr_latch_bank #(
  parameter int unsigned NSRC      = 12,
  parameter logic [NSRC-1:0] LEVEL_MAP = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] lat_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (LEVEL_MAP[g]) begin : g_level
      // live level sources are formed outside; no storage here
      assign lat_o[g] = 1'b0;
    end else begin : g_sticky
      logic lat_q;
      logic lat_d;
      logic lat_en;

      // a new event wins over a clear in the same cycle
      always_comb begin
        lat_en = evt_i[g] | clr_i[g];
        lat_d  = evt_i[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lat_q <= 1'b0;
        else if (lat_en) lat_q <= lat_d;
      end

      assign lat_o[g] = lat_q;

      a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[g] |=> lat_q);
      a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[g] && !evt_i[g]) |=> !lat_q);
      a_r1_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q && !clr_i[g]) |=> lat_q);
    end
  end
endmodule

// File: rtl/isr_abort_hold.sv
module isr_abort_hold #(
  parameter int unsigned ABRT_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ABRT_W-1:0] cause_i,
  input  logic              clr_i,
  output logic [ABRT_W-1:0] cause_o
);
  logic [ABRT_W-1:0] cause_q;
  logic [ABRT_W-1:0] cause_d;
  logic              cause_en;

  always_comb begin
    cause_en = clr_i | (|cause_i);
    cause_d  = clr_i ? cause_i : (cause_q | cause_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  assign cause_o = cause_q;

  a_r7_abort_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
  a_r7_abort_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && cause_i == '0) |=> (cause_q == '0));
endmodule

// File: rtl/isr_regif.sv
module isr_regif #(
  parameter int unsigned NSRC      = 12,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 13,
  parameter int unsigned LVL_W     = 5,
  parameter int unsigned ABRT_W    = 13,
  parameter logic [NSRC-1:0] LEVEL_MAP = '0,
  parameter logic [NSRC-1:0] MASK_RST  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSRC-1:0]   wdata_i,
  input  logic [NSRC-1:0]   raw_i,
  input  logic [ABRT_W-1:0] abort_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NSRC-1:0]   mask_o,
  output logic [NSRC-1:0]   masked_o,
  output logic [LVL_W-1:0]  rx_thr_o,
  output logic [LVL_W-1:0]  tx_thr_o,
  output logic [NSRC-1:0]   clr_o,
  output logic              clr_all_o
);
  import isr_pkg::*;

  localparam logic [ADDR_W-1:0] A_MASKED  = ADDR_W'(OFS_MASKED);
  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_RAW     = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_RX_THR  = ADDR_W'(OFS_RX_THR);
  localparam logic [ADDR_W-1:0] A_TX_THR  = ADDR_W'(OFS_TX_THR);
  localparam logic [ADDR_W-1:0] A_CLR_ALL = ADDR_W'(OFS_CLR_ALL);
  localparam logic [ADDR_W-1:0] A_ABORT   = ADDR_W'(OFS_ABORT);

  // position of a sticky source among the sticky ones (sets its clear address)
  function automatic int unsigned sticky_rank(int unsigned idx);
    int unsigned n = 0;
    for (int unsigned j = 0; j < idx; j++)
      if (!LEVEL_MAP[j]) n++;
    return n;
  endfunction

  logic [NSRC-1:0]  mask_q, mask_d;
  logic [LVL_W-1:0] rx_thr_q, rx_thr_d;
  logic [LVL_W-1:0] tx_thr_q, tx_thr_d;
  logic             mask_we, rx_thr_we, tx_thr_we;

  always_comb begin
    mask_we   = wr_i && (addr_i == A_MASK);
    rx_thr_we = wr_i && (addr_i == A_RX_THR);
    tx_thr_we = wr_i && (addr_i == A_TX_THR);
    mask_d    = wdata_i;
    rx_thr_d  = wdata_i[LVL_W-1:0];
    tx_thr_d  = wdata_i[LVL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= MASK_RST;
    else if (mask_we) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rx_thr_q <= '0;
    else if (rx_thr_we) rx_thr_q <= rx_thr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tx_thr_q <= '0;
    else if (tx_thr_we) tx_thr_q <= tx_thr_d;
  end

  // per-source clear-on-read decode
  for (genvar g = 0; g < NSRC; g++) begin : g_clr
    if (LEVEL_MAP[g]) begin : g_none
      assign clr_o[g] = 1'b0;
    end else begin : g_dec
      localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_CLR_BASE + 4 * sticky_rank(g));
      assign clr_o[g] = rd_i && (addr_i == A_CLR);
    end
  end

  assign clr_all_o = rd_i && (addr_i == A_CLR_ALL);

  always_comb begin
    masked_o = raw_i & mask_q;
    case (addr_i)
      A_MASKED: rdata_o = DATA_W'(masked_o);
      A_MASK:   rdata_o = DATA_W'(mask_q);
      A_RAW:    rdata_o = DATA_W'(raw_i);
      A_RX_THR: rdata_o = DATA_W'(rx_thr_q);
      A_TX_THR: rdata_o = DATA_W'(tx_thr_q);
      A_ABORT:  rdata_o = DATA_W'(abort_i);
      default:  rdata_o = '0;
    endcase
  end

  assign mask_o   = mask_q;
  assign rx_thr_o = rx_thr_q;
  assign tx_thr_o = tx_thr_q;

  a_r3_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_o));
  a_r2_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mask_q));
endmodule

// File: rtl/isr_ctrl.sv
module isr_ctrl #(
  parameter int unsigned NSRC       = 12,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned ABRT_W     = 13,
  localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1),
  localparam int unsigned DATA_W    = (NSRC > ABRT_W) ? NSRC : ABRT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [NSRC-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [NSRC-1:0]   evt_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [ABRT_W-1:0] abrt_cause_i,
  output logic              irq_o
);
  import isr_pkg::*;

  localparam logic [NSRC-1:0] LEVEL_MAP = NSRC'(LEVEL_SRC_MAP);
  localparam logic [NSRC-1:0] MASK_RST  = NSRC'(MASK_RESET);

  logic [NSRC-1:0]   lat;
  logic [NSRC-1:0]   raw;
  logic [NSRC-1:0]   mask;
  logic [NSRC-1:0]   masked;
  logic [NSRC-1:0]   clr_src;
  logic [NSRC-1:0]   clr_eff;
  logic              clr_all;
  logic [LVL_W-1:0]  rx_thr, tx_thr;
  logic              rx_full, tx_empty;
  logic [ABRT_W-1:0] abort_word;
  logic              irq_q, irq_d;

  isr_regif #(
    .NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W),
    .ABRT_W(ABRT_W), .LEVEL_MAP(LEVEL_MAP), .MASK_RST(MASK_RST)
  ) u_regif (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .rd_i(reg_rd_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .raw_i(raw),
    .abort_i(abort_word), .rdata_o(reg_rdata_o), .mask_o(mask),
    .masked_o(masked), .rx_thr_o(rx_thr), .tx_thr_o(tx_thr),
    .clr_o(clr_src), .clr_all_o(clr_all)
  );

  assign clr_eff = clr_src | {NSRC{clr_all}};

  isr_latch_bank #(.NSRC(NSRC), .LEVEL_MAP(LEVEL_MAP)) u_latch (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr_eff), .lat_o(lat)
  );

  isr_level_cmp #(.LVL_W(LVL_W)) u_level (
    .rx_level_i(rx_level_i), .tx_level_i(tx_level_i),
    .rx_thr_i(rx_thr), .tx_thr_i(tx_thr),
    .rx_full_o(rx_full), .tx_empty_o(tx_empty)
  );

  isr_abort_hold #(.ABRT_W(ABRT_W)) u_abort (
    .clk(clk), .rst_n(rst_n), .cause_i(abrt_cause_i),
    .clr_i(clr_eff[SRC_TX_ABORT]), .cause_o(abort_word)
  );

  always_comb begin
    raw               = lat;
    raw[SRC_RX_FULL]  = rx_full;
    raw[SRC_TX_EMPTY] = tx_empty;
    irq_d             = |masked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  a_r8_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_o == $past(|(raw & mask))));
  a_r6_level_unclearable: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && $stable(rx_level_i) && $stable(rx_thr)) |=> $stable(raw[SRC_RX_FULL]));
endmodule

// File: tb/test_isr_ctrl.sv
module test_isr_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_i, reg_rd_i;
  logic [7:0]  reg_addr_i;
  logic [11:0] reg_wdata_i;
  logic [12:0] reg_rdata_o;
  logic [11:0] evt_i;
  logic [4:0]  rx_level_i, tx_level_i;
  logic [12:0] abrt_cause_i;
  logic        irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  isr_ctrl i_isr_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .evt_i(evt_i), .rx_level_i(rx_level_i), .tx_level_i(tx_level_i),
    .abrt_cause_i(abrt_cause_i), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  task automatic check(input int act, input int exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = 8'(a); reg_wdata_i = 12'(d);
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_rd_i = 1'b1; reg_addr_i = 8'(a);
    #1 d = int'(reg_rdata_o);
    @(negedge clk);
    reg_rd_i = 1'b0;
  endtask

  task automatic pulse(input int e, input int ab);
    @(negedge clk);
    evt_i = 12'(e); abrt_cause_i = 13'(ab);
    @(negedge clk);
    evt_i = '0; abrt_cause_i = '0;
  endtask

  function automatic int sticky_bit(input int k);
    int n = 0;
    for (int b = 0; b < 12; b++) begin
      if (b != 2 && b != 4) begin
        if (n == k) return b;
        n++;
      end
    end
    return -1;
  endfunction

  task automatic t_reset();
    int d;
    check(int'(irq_o), 0, "R9 irq in reset");
    rst_n = 1'b1;
    rd('h34, d); check(d, 'h010, "R9 raw after reset");
    rd('h30, d); check(d, 'h254, "R9 mask after reset");
    rd('h38, d); check(d, 0, "R9 rx threshold after reset");
    rd('h80, d); check(d, 0, "R9 abort after reset");
    tx_level_i = 5'd10;
    rd('h34, d); check(d, 0, "R6 tx empty off above threshold");
  endtask

  task automatic t_latch();
    int d;
    pulse('hFFF, 0);
    rd('h34, d); check(d, 'hFEB, "R1 sticky set, R6 level pulses ignored");
    repeat (3) @(negedge clk);
    rd('h34, d); check(d, 'hFEB, "R1 sticky hold");
  endtask

  task automatic t_per_clear();
    int d;
    int exp = 'hFEB;
    for (int k = 0; k < 10; k++) begin
      rd('h44 + 4 * k, d); check(d, 0, "R3 clear reads zero");
      exp &= ~(1 << sticky_bit(k));
      rd('h34, d); check(d, exp, "R3 only own bit cleared");
    end
  endtask

  task automatic t_clear_all();
    int d;
    pulse('hFEB, 'h005);
    rd('h40, d);
    rd('h34, d); check(d, 0, "R4 combined clear of sources");
    rd('h80, d); check(d, 0, "R4 combined clear of abort");
  endtask

  task automatic t_same_cycle();
    int d;
    pulse(1 << 9, 0);
    @(negedge clk);
    reg_rd_i = 1'b1; reg_addr_i = 8'h60; evt_i = 12'(1 << 9);
    @(negedge clk);
    reg_rd_i = 1'b0; evt_i = '0;
    rd('h34, d); check(d, 'h200, "R5 event beats own clear");
    @(negedge clk);
    reg_rd_i = 1'b1; reg_addr_i = 8'h60; evt_i = 12'(1 << 10);
    @(negedge clk);
    reg_rd_i = 1'b0; evt_i = '0;
    rd('h34, d); check(d, 'h400, "R5 other source event kept, own bit cleared");
    @(negedge clk);
    reg_rd_i = 1'b1; reg_addr_i = 8'h40; evt_i = 12'(1 << 0);
    @(negedge clk);
    reg_rd_i = 1'b0; evt_i = '0;
    rd('h34, d); check(d, 'h001, "R5 event beats combined clear");
    rd('h40, d);
  endtask

  task automatic t_levels();
    int d;
    wr('h38, 3);
    rx_level_i = 5'd3;
    rd('h34, d); check(d, 0, "R6 rx full off at threshold");
    rx_level_i = 5'd4;
    rd('h34, d); check(d, 'h004, "R6 rx full above threshold");
    rd('h40, d);
    rd('h34, d); check(d, 'h004, "R6 rx full survives clear");
    rx_level_i = 5'd0;
    wr('h3c, 2);
    tx_level_i = 5'd3;
    rd('h34, d); check(d, 0, "R6 tx empty off above threshold");
    tx_level_i = 5'd2;
    rd('h34, d); check(d, 'h010, "R6 tx empty at threshold");
    tx_level_i = 5'd10;
  endtask

  task automatic t_mask();
    int d;
    wr('h30, 'h201);
    rd('h30, d); check(d, 'h201, "R2 mask write");
    pulse('h203, 0);
    rd('h2c, d); check(d, 'h201, "R2 masked equals raw and mask");
    wr('h34, 0);
    rd('h34, d); check(d, 'h203, "R9 write to raw ignored");
    rd('h90, d); check(d, 0, "R9 unmapped reads zero");
    rd('h40, d);
  endtask

  task automatic t_irq();
    int d;
    wr('h30, 0);
    pulse(1 << 5, 0);
    check(int'(irq_o), 0, "R8 irq off when masked");
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = 8'h30; reg_wdata_i = 12'h020;
    @(negedge clk);
    reg_wr_i = 1'b0;
    check(int'(irq_o), 0, "R8 irq one edge late");
    @(negedge clk);
    check(int'(irq_o), 1, "R8 irq after mask");
    rd('h50, d);
    @(negedge clk);
    check(int'(irq_o), 0, "R8 irq drops after clear");
  endtask

  task automatic t_abort();
    int d;
    pulse(1 << 6, 'h0009);
    pulse(0, 'h1000);
    rd('h80, d); check(d, 'h1009, "R7 abort accumulates");
    rd('h48, d);
    rd('h80, d); check(d, 'h1009, "R7 abort kept across other clear");
    rd('h54, d);
    rd('h80, d); check(d, 0, "R7 abort cleared by tx abort clear");
    rd('h34, d); check(d, 0, "R7 tx abort bit cleared");
  endtask

  initial begin
    rst_n = 1'b0; reg_wr_i = 1'b0; reg_rd_i = 1'b0; reg_addr_i = '0;
    reg_wdata_i = '0; evt_i = '0; rx_level_i = '0; tx_level_i = '0;
    abrt_cause_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_latch();
    t_per_clear();
    t_clear_all();
    t_same_cycle();
    t_levels();
    t_mask();
    t_irq();
    t_abort();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule